// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits in the decode stage of an RV64 core. Each cycle it looks at two adjacent 32-bit instructions in program order, an older one and a younger one. It decides whether the pair can be issued as a single internal macro-operation. It knows a fixed set of thirteen fusion classes. Each class is defined by the opcodes of both instructions and, where an immediate or shift amount matters, by its exact value. A pair whose immediate is one off from a listed value is not fused.

A pair fuses only when four conditions hold. Both slots are valid. The younger instruction consumes the older one's result and overwrites the same register. That register is not x0. The class's bit in the enable mask is set. If more than one class could apply, the lowest class number wins.

The result is registered one cycle after the inputs. It consists of a fuse flag, the class code, a small auxiliary field (for example the shift amount), and the register indices the fused operation needs.

Top module: `fusion_pair_detect`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets every output to zero; fuse_valid is low after reset.
- R2: Outputs reflect the inputs present at the previous rising clock edge and hold until the next edge.
- R3: Class 1 is SLLIW by 16 (opcode 0011011, funct3 001, funct7 0) followed by SRLIW by 16 (funct3 101, funct7 0). Class 2 is SLLIW by 16 followed by SRAIW by 16 (funct7 0100000). Any other shift amount does not fuse.
- R4: Class 3 is SLLI (opcode 0010011, funct3 001, imm[11:6]=0) by 1, 2, 3 or 4 followed by ADD (opcode 0110011, funct3 000, funct7 0); aux is the shift amount. An amount of 0 or 5 does not fuse.
- R5: Class 4 is SLLI by 32 followed by SRLI (funct3 101, imm[11:6]=0) by 29, 30 or 31; aux is 32 minus the SRLI amount. Class 5 is SRLI by 8 followed by ANDI (funct3 111) with immediate 255.
- R6: Class 6 is SRLI by 29, 30, 31 or 32 followed by ADD; aux is the shift amount. An amount of 33 does not fuse.
- R7: Class 7 is ANDI 1 followed by ADD (aux 0) or ADDW (opcode 0111011, funct3 000, funct7 0; aux 1). Class 12 is ANDI -256 followed by OR (funct3 110). Class 13 is ANDI 127 followed by MULW (funct7 0000001).
- R8: Class 8 is ADDW followed by ANDI 1 (aux 1) or ANDI 255 (aux 8). Class 9 is ADDW followed by ZEXT.H (opcode 0111011, funct3 100, funct7 0000100, rs2 0; aux 0) or SEXT.H (opcode 0010011, funct3 001, imm 0x605; aux 1).
- R9: Class 10 is any of AND, OR, XOR, ANDI, ORI, XORI or ORC.B (opcode 0010011, funct3 101, imm 0x287) followed by ANDI 1. Class 11 is the same set followed by ZEXT.H.
- R10: A pair fuses only if the older rd (bits 11:7) is not x0, the younger rd equals it, and the younger reads it: through rs1 (bits 19:15) for an immediate or unary younger instruction, through rs1 or rs2 (bits 24:20) for a register-register one.
- R11: When fused, fuse_rd is the older rd and fuse_rs1 is the older rs1. fuse_rs2 is the older rs2 if the older instruction is register-register. Otherwise it is the younger operand that is not the fused register when the younger is register-register, and 0 in all other cases.
- R12: Fusion requires both first_valid and second_valid and class_enable bit (class-1) to be high.
- R13: When not fused, fuse_class, fuse_aux, fuse_rd, fuse_rs1 and fuse_rs2 are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| first_valid | input | 1 | Older slot holds an instruction |
| first_insn | input | 32 | Older instruction word |
| second_valid | input | 1 | Younger slot holds an instruction |
| second_insn | input | 32 | Younger instruction word |
| class_enable | input | 13 | Per-class enable, bit k enables class k+1 |
| fuse_valid | output | 1 | Registered: the pair fuses |
| fuse_class | output | 4 | Registered class code, 0 when not fused |
| fuse_aux | output | 6 | Registered class-specific detail (shift amount, width, variant) |
| fuse_rd | output | 5 | Registered destination of the fused op |
| fuse_rs1 | output | 5 | Registered first source of the fused op |
| fuse_rs2 | output | 5 | Registered second source of the fused op, 0 if none |

## Verification
The bench drives every class with an exact immediate and with a neighbouring value: 15 against 16, 28 against 29, 33 against 32, 254 against 255, 256 and 128. A decoder that matched only the opcode class would fuse these neighbours and be caught. It breaks the register chain in each possible way: wrong younger rd, a younger instruction that does not read the result, and a result written to x0. An over-eager dependency check shows up as a spurious fuse. For register-register younger instructions it puts the dependency on rs2 as well as rs1. A design that chose the wrong other operand would report the wrong fuse_rs2. Clearing a single enable bit or either valid bit must kill the fuse, and a reset during a fused cycle must clear the flag on the next edge.

// File: rtl/fusion_pkg.sv
package fusion_pkg;

    localparam int INSN_W    = 32;
    localparam int REG_W     = 5;
    localparam int IMM_W     = 12;
    localparam int NUM_CLASS = 13;
    localparam int CLASS_W   = $clog2(NUM_CLASS + 1);
    localparam int AUX_W     = 6;

    typedef enum logic [4:0] {
        K_OTHER, K_SLLIW, K_SRLIW, K_SRAIW, K_SLLI, K_SRLI,
        K_ANDI, K_ORI, K_XORI, K_ORCB, K_ADD, K_AND, K_OR, K_XOR,
        K_ADDW, K_MULW, K_ZEXTH, K_SEXTH
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic [IMM_W-1:0]   imm12;
    } slot_dec_t;

    typedef struct packed {
        logic               fuse;
        logic [CLASS_W-1:0] cls;
        logic [AUX_W-1:0]   aux;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
    } fuse_out_t;

endpackage

// File: rtl/fusion_slot_decode.sv
module fusion_slot_decode
    import fusion_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output slot_dec_t         dec
);
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_IMM32  = 7'b0011011;
    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_REG32  = 7'b0111011;
    localparam logic [IMM_W-1:0] IMM_SEXTH = 12'h605;
    localparam logic [IMM_W-1:0] IMM_ORCB  = 12'h287;

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [5:0] f6;

    always_comb begin
        opc = insn[6:0];
        f3  = insn[14:12];
        f7  = insn[31:25];
        f6  = insn[31:26];

        dec.rd    = insn[11:7];
        dec.rs1   = insn[19:15];
        dec.rs2   = insn[24:20];
        dec.imm12 = insn[31:20];
        dec.kind  = K_OTHER;

        unique case (opc)
            OPC_IMM: begin
                case (f3)
                    3'b001: begin
                        if (f6 == 6'd0)                 dec.kind = K_SLLI;
                        else if (insn[31:20] == IMM_SEXTH) dec.kind = K_SEXTH;
                    end
                    3'b101: begin
                        if (f6 == 6'd0)                 dec.kind = K_SRLI;
                        else if (insn[31:20] == IMM_ORCB)  dec.kind = K_ORCB;
                    end
                    3'b111: dec.kind = K_ANDI;
                    3'b110: dec.kind = K_ORI;
                    3'b100: dec.kind = K_XORI;
                    default: dec.kind = K_OTHER;
                endcase
            end
            OPC_IMM32: begin
                if (f3 == 3'b001 && f7 == 7'd0)              dec.kind = K_SLLIW;
                else if (f3 == 3'b101 && f7 == 7'd0)         dec.kind = K_SRLIW;
                else if (f3 == 3'b101 && f7 == 7'b0100000)   dec.kind = K_SRAIW;
            end
            OPC_REG: begin
                if (f7 == 7'd0) begin
                    case (f3)
                        3'b000: dec.kind = K_ADD;
                        3'b111: dec.kind = K_AND;
                        3'b110: dec.kind = K_OR;
                        3'b100: dec.kind = K_XOR;
                        default: dec.kind = K_OTHER;
                    endcase
                end
            end
            OPC_REG32: begin
                if (f3 == 3'b000 && f7 == 7'd0)              dec.kind = K_ADDW;
                else if (f3 == 3'b000 && f7 == 7'b0000001)   dec.kind = K_MULW;
                else if (f3 == 3'b100 && f7 == 7'b0000100 && insn[24:20] == 5'd0)
                                                             dec.kind = K_ZEXTH;
            end
            default: dec.kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/fusion_pair_match.sv
module fusion_pair_match
    import fusion_pkg::*;
(
    input  logic                 a_valid,
    input  slot_dec_t            a,
    input  logic                 b_valid,
    input  slot_dec_t            b,
    input  logic [NUM_CLASS-1:0] enable,
    output fuse_out_t            result
);
    localparam logic [IMM_W-1:0] IMM_ONE   = 12'h001;
    localparam logic [IMM_W-1:0] IMM_BYTE  = 12'h0FF;
    localparam logic [IMM_W-1:0] IMM_M256  = 12'hF00;
    localparam logic [IMM_W-1:0] IMM_SEVEN = 12'h07F;

    logic [5:0]           a_sh;
    logic [5:0]           b_sh;
    logic                 chain_ok;
    logic                 dep_i;
    logic                 dep_r;
    logic                 a_logic;
    logic                 a_is_r;
    logic [NUM_CLASS:1]   shape;
    logic [NUM_CLASS:1]   b_is_r_class;
    logic [NUM_CLASS:1]   hit;
    logic [CLASS_W-1:0]   win;
    logic                 found;

    always_comb begin
        a_sh     = a.imm12[5:0];
        b_sh     = b.imm12[5:0];
        chain_ok = a_valid && b_valid && (a.rd != '0) && (b.rd == a.rd);
        dep_i    = (b.rs1 == a.rd);
        dep_r    = (b.rs1 == a.rd) || (b.rs2 == a.rd);
        a_is_r   = (a.kind == K_AND) || (a.kind == K_OR) || (a.kind == K_XOR) || (a.kind == K_ADDW);
        a_logic  = (a.kind == K_AND) || (a.kind == K_OR) || (a.kind == K_XOR) ||
                   (a.kind == K_ANDI) || (a.kind == K_ORI) || (a.kind == K_XORI) ||
                   (a.kind == K_ORCB);

        // Opcode and immediate shape of each class, catalogue order
        shape[1]  = (a.kind == K_SLLIW) && (a_sh == 6'd16) && (b.kind == K_SRLIW) && (b_sh == 6'd16);
        shape[2]  = (a.kind == K_SLLIW) && (a_sh == 6'd16) && (b.kind == K_SRAIW) && (b_sh == 6'd16);
        shape[3]  = (a.kind == K_SLLI) && (a_sh >= 6'd1) && (a_sh <= 6'd4) && (b.kind == K_ADD);
        shape[4]  = (a.kind == K_SLLI) && (a_sh == 6'd32) && (b.kind == K_SRLI) &&
                    (b_sh >= 6'd29) && (b_sh <= 6'd31);
        shape[5]  = (a.kind == K_SRLI) && (a_sh == 6'd8) && (b.kind == K_ANDI) && (b.imm12 == IMM_BYTE);
        shape[6]  = (a.kind == K_SRLI) && (a_sh >= 6'd29) && (a_sh <= 6'd32) && (b.kind == K_ADD);
        shape[7]  = (a.kind == K_ANDI) && (a.imm12 == IMM_ONE) && ((b.kind == K_ADD) || (b.kind == K_ADDW));
        shape[8]  = (a.kind == K_ADDW) && (b.kind == K_ANDI) &&
                    ((b.imm12 == IMM_ONE) || (b.imm12 == IMM_BYTE));
        shape[9]  = (a.kind == K_ADDW) && ((b.kind == K_ZEXTH) || (b.kind == K_SEXTH));
        shape[10] = a_logic && (b.kind == K_ANDI) && (b.imm12 == IMM_ONE);
        shape[11] = a_logic && (b.kind == K_ZEXTH);
        shape[12] = (a.kind == K_ANDI) && (a.imm12 == IMM_M256) && (b.kind == K_OR);
        shape[13] = (a.kind == K_ANDI) && (a.imm12 == IMM_SEVEN) && (b.kind == K_MULW);

        b_is_r_class = '0;
        b_is_r_class[3]  = 1'b1;
        b_is_r_class[6]  = 1'b1;
        b_is_r_class[7]  = 1'b1;
        b_is_r_class[12] = 1'b1;
        b_is_r_class[13] = 1'b1;
    end

    for (genvar c = 1; c <= NUM_CLASS; c++) begin : g_hit
        assign hit[c] = shape[c] && chain_ok && enable[c-1] &&
                        (b_is_r_class[c] ? dep_r : dep_i);
    end

    // Fixed priority: lowest class number wins
    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int c = 1; c <= NUM_CLASS; c++) begin
            if (!found && hit[c]) begin
                win   = CLASS_W'(c);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        result = '0;
        if (found) begin
            result.fuse = 1'b1;
            result.cls  = win;
            result.rd   = a.rd;
            result.rs1  = a.rs1;
            if (a_is_r)
                result.rs2 = a.rs2;
            else if (b_is_r_class[win])
                result.rs2 = (b.rs1 == a.rd) ? b.rs2 : b.rs1;
            case (win)
                CLASS_W'(3):  result.aux = a_sh;
                CLASS_W'(4):  result.aux = 6'd32 - b_sh;
                CLASS_W'(6):  result.aux = a_sh;
                CLASS_W'(7):  result.aux = (b.kind == K_ADDW) ? 6'd1 : 6'd0;
                CLASS_W'(8):  result.aux = (b.imm12 == IMM_ONE) ? 6'd1 : 6'd8;
                CLASS_W'(9):  result.aux = (b.kind == K_SEXTH) ? 6'd1 : 6'd0;
                default:      result.aux = '0;
            endcase
        end
    end
endmodule

// File: rtl/fusion_pair_detect.sv
module fusion_pair_detect
    import fusion_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 first_valid,
    input  logic [INSN_W-1:0]    first_insn,
    input  logic                 second_valid,
    input  logic [INSN_W-1:0]    second_insn,
    input  logic [NUM_CLASS-1:0] class_enable,
    output logic                 fuse_valid,
    output logic [CLASS_W-1:0]   fuse_class,
    output logic [AUX_W-1:0]     fuse_aux,
    output logic [REG_W-1:0]     fuse_rd,
    output logic [REG_W-1:0]     fuse_rs1,
    output logic [REG_W-1:0]     fuse_rs2
);
    localparam int NUM_SLOTS = 2;

    logic [NUM_SLOTS-1:0][INSN_W-1:0] slot_insn;
    slot_dec_t                        slot_dec [NUM_SLOTS];
    fuse_out_t                        match_res;
    fuse_out_t                        out_d;
    fuse_out_t                        out_q;

    assign slot_insn[0] = first_insn;
    assign slot_insn[1] = second_insn;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        fusion_slot_decode u_dec (
            .insn (slot_insn[s]),
            .dec  (slot_dec[s])
        );
    end

    fusion_pair_match u_match (
        .a_valid (first_valid),
        .a       (slot_dec[0]),
        .b_valid (second_valid),
        .b       (slot_dec[1]),
        .enable  (class_enable),
        .result  (match_res)
    );

    always_comb begin
        out_d = rst ? '0 : match_res;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign fuse_valid = out_q.fuse;
    assign fuse_class = out_q.cls;
    assign fuse_aux   = out_q.aux;
    assign fuse_rd    = out_q.rd;
    assign fuse_rs1   = out_q.rs1;
    assign fuse_rs2   = out_q.rs2;

    assert_fuse_needs_valid_R12: assert property (@(posedge clk) disable iff (rst)
        fuse_valid |-> $past(first_valid && second_valid));

    assert_fuse_needs_enable_R12: assert property (@(posedge clk) disable iff (rst)
        fuse_valid |-> ((($past(class_enable)) >> (fuse_class - CLASS_W'(1))) & NUM_CLASS'(1)) != '0);

    assert_chain_rd_R10: assert property (@(posedge clk) disable iff (rst)
        fuse_valid |-> (fuse_rd != '0) && (fuse_rd == $past(first_insn[11:7]))
                        && ($past(second_insn[11:7]) == fuse_rd));

    assert_src_rs1_R11: assert property (@(posedge clk) disable iff (rst)
        fuse_valid |-> fuse_rs1 == $past(first_insn[19:15]));

    assert_class_range_R13: assert property (@(posedge clk) disable iff (rst)
        fuse_valid |-> (fuse_class != '0) && (fuse_class <= CLASS_W'(NUM_CLASS)));

    assert_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
        !fuse_valid |-> (fuse_class == '0) && (fuse_aux == '0) && (fuse_rd == '0)
                        && (fuse_rs1 == '0) && (fuse_rs2 == '0));
endmodule

// File: tb/fusion_pair_detect_test.sv
module fusion_pair_detect_test;
    import fusion_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // Instruction builders
    function automatic logic [31:0] f_slliw(input logic [4:0] rd, rs1, input int sh);
        return {7'b0, 5'(sh), rs1, 3'b001, rd, 7'b0011011};
    endfunction
    function automatic logic [31:0] f_srliw(input logic [4:0] rd, rs1, input int sh);
        return {7'b0, 5'(sh), rs1, 3'b101, rd, 7'b0011011};
    endfunction
    function automatic logic [31:0] f_sraiw(input logic [4:0] rd, rs1, input int sh);
        return {7'b0100000, 5'(sh), rs1, 3'b101, rd, 7'b0011011};
    endfunction
    function automatic logic [31:0] f_slli(input logic [4:0] rd, rs1, input int sh);
        return {6'b0, 6'(sh), rs1, 3'b001, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] f_srli(input logic [4:0] rd, rs1, input int sh);
        return {6'b0, 6'(sh), rs1, 3'b101, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] f_iop(input logic [2:0] f3, input logic [4:0] rd, rs1,
                                          input logic [11:0] imm);
        return {imm, rs1, f3, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] f_rop(input logic [6:0] opc, f7, input logic [2:0] f3,
                                          input logic [4:0] rd, rs1, rs2);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction
    function automatic logic [31:0] f_zexth(input logic [4:0] rd, rs1);
        return {7'b0000100, 5'd0, rs1, 3'b100, rd, 7'b0111011};
    endfunction

    localparam logic [2:0] ANDI = 3'b111, ORI = 3'b110, XORI = 3'b100;
    localparam logic [6:0] OPR = 7'b0110011, OPW = 7'b0111011;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  cls;
        logic [5:0]  aux;
        logic [4:0]  rs2;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        // R3
        '{f_slliw(5,6,16), f_srliw(5,5,16), 4'd1, 6'd0, 5'd0},
        '{f_slliw(5,6,16), f_srliw(5,5,15), 4'd0, 6'd0, 5'd0},
        '{f_slliw(5,6,16), f_sraiw(5,5,16), 4'd2, 6'd0, 5'd0},
        '{f_slliw(5,6,17), f_sraiw(5,5,16), 4'd0, 6'd0, 5'd0},
        // R4
        '{f_slli(5,6,1), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd3, 6'd1, 5'd7},
        '{f_slli(5,6,4), f_rop(OPR,7'd0,3'b000,5,7,5), 4'd3, 6'd4, 5'd7},
        '{f_slli(5,6,5), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd0, 6'd0, 5'd0},
        '{f_slli(5,6,0), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd0, 6'd0, 5'd0},
        // R5
        '{f_slli(5,6,32), f_srli(5,5,29), 4'd4, 6'd3, 5'd0},
        '{f_slli(5,6,32), f_srli(5,5,31), 4'd4, 6'd1, 5'd0},
        '{f_slli(5,6,32), f_srli(5,5,28), 4'd0, 6'd0, 5'd0},
        '{f_slli(5,6,31), f_srli(5,5,30), 4'd0, 6'd0, 5'd0},
        '{f_srli(5,6,8), f_iop(ANDI,5,5,12'h0FF), 4'd5, 6'd0, 5'd0},
        '{f_srli(5,6,8), f_iop(ANDI,5,5,12'h0FE), 4'd0, 6'd0, 5'd0},
        // R6
        '{f_srli(5,6,29), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd6, 6'd29, 5'd7},
        '{f_srli(5,6,32), f_rop(OPR,7'd0,3'b000,5,7,5), 4'd6, 6'd32, 5'd7},
        '{f_srli(5,6,33), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd0, 6'd0, 5'd0},
        // R7
        '{f_iop(ANDI,5,6,12'h001), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd7, 6'd0, 5'd7},
        '{f_iop(ANDI,5,6,12'h001), f_rop(OPW,7'd0,3'b000,5,5,7), 4'd7, 6'd1, 5'd7},
        '{f_iop(ANDI,5,6,12'h002), f_rop(OPR,7'd0,3'b000,5,5,7), 4'd0, 6'd0, 5'd0},
        '{f_iop(ANDI,5,6,12'hF00), f_rop(OPR,7'd0,3'b110,5,5,7), 4'd12, 6'd0, 5'd7},
        '{f_iop(ANDI,5,6,12'hF01), f_rop(OPR,7'd0,3'b110,5,5,7), 4'd0, 6'd0, 5'd0},
        '{f_iop(ANDI,5,6,12'h07F), f_rop(OPW,7'd1,3'b000,5,5,7), 4'd13, 6'd0, 5'd7},
        '{f_iop(ANDI,5,6,12'h080), f_rop(OPW,7'd1,3'b000,5,5,7), 4'd0, 6'd0, 5'd0},
        // R8
        '{f_rop(OPW,7'd0,3'b000,5,6,8), f_iop(ANDI,5,5,12'h001), 4'd8, 6'd1, 5'd8},
        '{f_rop(OPW,7'd0,3'b000,5,6,8), f_iop(ANDI,5,5,12'h0FF), 4'd8, 6'd8, 5'd8},
        '{f_rop(OPW,7'd0,3'b000,5,6,8), f_iop(ANDI,5,5,12'h100), 4'd0, 6'd0, 5'd0},
        '{f_rop(OPW,7'd0,3'b000,5,6,8), f_zexth(5,5), 4'd9, 6'd0, 5'd8},
        '{f_rop(OPW,7'd0,3'b000,5,6,8), f_iop(3'b001,5,5,12'h605), 4'd9, 6'd1, 5'd8},
        // R9
        '{f_rop(OPR,7'd0,3'b111,5,6,8), f_iop(ANDI,5,5,12'h001), 4'd10, 6'd0, 5'd8},
        '{f_iop(XORI,5,6,12'h0F0), f_iop(ANDI,5,5,12'h001), 4'd10, 6'd0, 5'd0},
        '{f_iop(3'b101,5,6,12'h287), f_zexth(5,5), 4'd11, 6'd0, 5'd0},
        '{f_rop(OPR,7'd0,3'b110,5,6,8), f_zexth(5,5), 4'd11, 6'd0, 5'd8},
        '{f_iop(ORI,5,6,12'h003), f_zexth(5,5), 4'd11, 6'd0, 5'd0},
        '{f_rop(OPR,7'd0,3'b100,5,6,8), f_iop(ANDI,5,5,12'h003), 4'd0, 6'd0, 5'd0},
        // R10
        '{f_slliw(5,6,16), f_srliw(6,5,16), 4'd0, 6'd0, 5'd0},
        '{f_slliw(5,6,16), f_srliw(5,6,16), 4'd0, 6'd0, 5'd0},
        '{f_slli(5,6,2), f_rop(OPR,7'd0,3'b000,5,7,8), 4'd0, 6'd0, 5'd0},
        '{f_slliw(0,6,16), f_srliw(0,0,16), 4'd0, 6'd0, 5'd0}
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 first_valid, second_valid;
    logic [31:0]          first_insn, second_insn;
    logic [NUM_CLASS-1:0] class_enable;
    logic                 fuse_valid;
    logic [CLASS_W-1:0]   fuse_class;
    logic [AUX_W-1:0]     fuse_aux;
    logic [REG_W-1:0]     fuse_rd, fuse_rs1, fuse_rs2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fusion_pair_detect uut (
        .clk, .rst, .first_valid, .first_insn, .second_valid, .second_insn,
        .class_enable, .fuse_valid, .fuse_class, .fuse_aux, .fuse_rd,
        .fuse_rs1, .fuse_rs2
    );

    task automatic drive(input logic [31:0] a, b, input logic va, vb,
                         input logic [NUM_CLASS-1:0] en);
        @(negedge clk);
        first_insn   = a;
        second_insn  = b;
        first_valid  = va;
        second_valid = vb;
        class_enable = en;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [3:0] cls, input logic [5:0] aux,
                         input logic [4:0] rd, rs1, rs2);
        logic [25:0] act, exp;
        act = {fuse_valid, fuse_class, fuse_aux, fuse_rd, fuse_rs1, fuse_rs2};
        exp = {cls != 4'd0, cls, aux, rd, rs1, rs2};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got fuse=%b cls=%0d aux=%0d rd=%0d rs1=%0d rs2=%0d, expected fuse=%b cls=%0d aux=%0d rd=%0d rs1=%0d rs2=%0d",
                     req, fuse_valid, fuse_class, fuse_aux, fuse_rd, fuse_rs1, fuse_rs2,
                     cls != 4'd0, cls, aux, rd, rs1, rs2);
        end
    endtask

    task automatic check_vec(input string req, input vec_t v);
        if (v.cls != 4'd0) check(req, v.cls, v.aux, 5'd5, 5'd6, v.rs2);
        else               check(req, 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);
    endtask

    initial begin
        rst = 1'b1;
        first_valid = 1'b1; second_valid = 1'b1;
        first_insn = f_slliw(5,6,16); second_insn = f_srliw(5,5,16);
        class_enable = '1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state with a fusing pair on the inputs
        check("R1 reset state", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk covers R3..R11, R13
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].a, VECS[i].b, 1'b1, 1'b1, '1);
            check_vec($sformatf("R3-class table vector %0d (R13 when unfused)", i), VECS[i]);
        end

        // R2: output holds between edges after inputs change
        drive(f_slli(5,6,3), f_rop(OPR,7'd0,3'b000,5,5,7), 1'b1, 1'b1, '1);
        @(negedge clk);
        first_insn = 32'h0000_0013;
        #2;
        check("R2 hold until edge", 4'd3, 6'd3, 5'd5, 5'd6, 5'd7);
        @(posedge clk); #1;
        check("R2 update at edge", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);

        // R12: valid bits and enable mask
        drive(f_slliw(5,6,16), f_srliw(5,5,16), 1'b0, 1'b1, '1);
        check("R12 first_valid low", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);
        drive(f_slliw(5,6,16), f_srliw(5,5,16), 1'b1, 1'b0, '1);
        check("R12 second_valid low", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);
        drive(f_slliw(5,6,16), f_srliw(5,5,16), 1'b1, 1'b1, 13'h1FFE);
        check("R12 class 1 disabled", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);
        drive(f_slliw(5,6,16), f_srliw(5,5,16), 1'b1, 1'b1, 13'h0001);
        check("R12 only class 1 enabled", 4'd1, 6'd0, 5'd5, 5'd6, 5'd0);
        drive(f_iop(ANDI,5,6,12'h07F), f_rop(OPW,7'd1,3'b000,5,5,7), 1'b1, 1'b1, 13'h0FFF);
        check("R12 class 13 disabled", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);

        // R11: other register numbers
        drive(f_srli(17,3,30), f_rop(OPR,7'd0,3'b000,17,17,29), 1'b1, 1'b1, '1);
        check("R11 register routing", 4'd6, 6'd30, 5'd17, 5'd3, 5'd29);

        // R1: reset during a fused cycle
        drive(f_slli(5,6,2), f_rop(OPR,7'd0,3'b000,5,5,7), 1'b1, 1'b1, '1);
        check("R1 fused before reset", 4'd3, 6'd2, 5'd5, 5'd6, 5'd7);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 cleared by reset", 4'd0, 6'd0, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 resumes after reset", 4'd3, 6'd2, 5'd5, 5'd6, 5'd7);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule